// File: doc/BRIEF.md
# Fixed-Point 4x4 Forward Transform

This block turns a 4x4 tile of signed 16-bit residual samples into sixteen signed 16-bit transform coefficients. It uses two separable integer passes with one constant 4x4 cosine matrix. Rows of samples enter one per handshake beat. Each accepted row is multiplied against the matrix at once and the result is stored in a small transpose buffer. Once the fourth row is in, the column pass reads the buffer and produces one output row of four coefficients per beat.

A wide mode treats each input row as eight samples, forming two horizontally adjacent tiles. Both tiles go through the row pass together. The left tile's four output rows are emitted first, then the right tile's four. The buffer cannot be refilled until its last output row has been taken. A new tile's first row may still enter in the same cycle that the final output row leaves.

Top module: `fdct4_xform`

## Requirements
- R1: The matrix C is, by rows, (23170, 30274, 23170, 12540), (23170, 12540, -23170, -30274), (23170, -12540, -23170, 30274), (23170, -30274, 23170, -12540). The row pass forms A[i][k] = sum over j of X[i][j]*C[j][k] using signed 16x16 products. The sum is kept in 32 bits and wraps on overflow.
- R2: Each row-pass sum is rounded with +8192 and shifted right arithmetically by 14 without intermediate overflow. Its low 16 bits are kept as T[i][k], with wraparound and no saturation.
- R3: The column pass forms Y[r][k] = sum over i of C[i][r]*T[i][k], wrapped to 32 bits. It adds 32768, shifts right arithmetically by 16 and keeps the low 16 bits.
- R4: Output beats come in row order r = 0..3. Coefficient Y[r][k] sits at out_row bits [16k+15:16k].
- R5: Input sample X[i][j] of a row sits at in_row bits [16j+15:16j]. In narrow mode (mode_wide low with the first row), bits 127:64 are ignored.
- R6: mode_wide is sampled with the first row of a tile. When it is high, samples at bits [16j+79:16j+64] form a right tile that is transformed the same way. Eight beats follow: the four left rows, then the four right rows.
- R7: out_last is high on the fourth beat of each 4x4 tile and low on every other beat.
- R8: While out_valid is high and out_ready low, out_row and out_last hold their values. in_ready stays low from the fourth accepted row until the final beat of the tile is accepted.
- R9: In the cycle in which the final beat of a tile is accepted, in_ready is high. The first row of the next tile may then be taken at the same edge.
- R10: After synchronous reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | Two-tile mode, sampled with the first row |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Input row accepted when high with in_valid |
| in_row | input | 128 | Eight signed 16-bit samples, lane j at bits 16j |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Sink accepts output row |
| out_row | output | 64 | Four signed 16-bit coefficients, lane k at bits 16k |
| out_last | output | 1 | Final row of a 4x4 tile |

## Verification
The two functions that can coincide are the final output beat of a tile leaving and the first input row of the next tile being written into the transpose buffer. The bench provokes this by holding out_ready high and presenting tiles back to back. It counts the cycles in which both handshakes fire, and it requires that count to be non-zero. Coefficients from those tiles are still compared bit-exactly against an integer model, which shows that the overwrite of row 0 did not disturb the beat leaving in that cycle.

// File: rtl/fx_pkg.sv
package fx_pkg;
    localparam int SW    = 16;
    localparam int LANES = 4;
    localparam int ROW_W = SW * LANES;

    typedef logic signed [SW-1:0] samp_t;
    typedef samp_t [LANES-1:0]    quad_t;
    typedef quad_t [LANES-1:0]    tmat_t;

    localparam samp_t K_A = 16'sd23170;
    localparam samp_t K_B = 16'sd30274;
    localparam samp_t K_C = 16'sd12540;

    // Constant cosine matrix, element (row, col)
    function automatic samp_t coef(input int row, input int col);
        samp_t v;
        case ({row[1:0], col[1:0]})
            4'h0, 4'h4, 4'h8, 4'hC: v = K_A;
            4'h1:                   v = K_B;
            4'h2, 4'hE:             v = K_A;
            4'h3, 4'h5:             v = K_C;
            4'h6, 4'hA:             v = -K_A;
            4'h7, 4'hD:             v = -K_B;
            4'h9, 4'hF:             v = -K_C;
            default:                v = K_B; // 4'hB
        endcase
        return v;
    endfunction

    // Row pass narrowing: +2^13, >>14, low half
    function automatic samp_t narrow_row(input logic signed [31:0] a);
        logic signed [32:0] s;
        s = 33'(a) + 33'sd8192;
        return s[29:14];
    endfunction

    // Column pass narrowing: +2^15, >>16, low half
    function automatic samp_t narrow_col(input logic signed [31:0] a);
        logic signed [32:0] s;
        s = 33'(a) + 33'sd32768;
        return s[31:16];
    endfunction

    typedef struct packed {
        quad_t data;
        logic  last;
    } beat_t;
endpackage

// File: rtl/fx_rowpass.sv
module fx_rowpass
    import fx_pkg::*;
(
    input  quad_t x,
    output quad_t t
);
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            logic signed [31:0] acc;
            acc = '0;
            for (int j = 0; j < LANES; j++) begin
                acc = acc + 32'($signed(x[j])) * 32'(coef(j, k));
            end
            t[k] = narrow_row(acc);
        end
    end

    always_comb begin
        if (x == '0) begin
            AST_ROW_ZERO: assert (t == '0); // R2
        end
    end
endmodule

// File: rtl/fx_colpass.sv
module fx_colpass
    import fx_pkg::*;
(
    input  tmat_t      tm,
    input  logic [1:0] r,
    output quad_t      y
);
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            logic signed [31:0] acc;
            acc = '0;
            for (int i = 0; i < LANES; i++) begin
                acc = acc + 32'(coef(i, int'(r))) * 32'($signed(tm[i][k]));
            end
            y[k] = narrow_col(acc);
        end
    end

    always_comb begin
        if (tm == '0) begin
            AST_COL_ZERO: assert (y == '0); // R3
        end
    end
endmodule

// File: rtl/fdct4_xform.sv
module fdct4_xform
    import fx_pkg::*;
#(
    parameter int MAX_BLK = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mode_wide,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [MAX_BLK*ROW_W-1:0]     in_row,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [ROW_W-1:0]             out_row,
    output logic                         out_last
);
    localparam int BLK_W = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1;

    tmat_t             t_buf [MAX_BLK];
    quad_t             t_new [MAX_BLK];
    logic [1:0]        wr_r, rd_r;
    logic [BLK_W-1:0]  rd_b, nblk_m1;
    logic              full;
    logic              in_fire, out_fire, last_all;
    quad_t             y_q;
    beat_t             beat;

    genvar b;
    generate
        for (b = 0; b < MAX_BLK; b++) begin : g_row
            fx_rowpass u_row (
                .x (quad_t'(in_row[b*ROW_W +: ROW_W])),
                .t (t_new[b])
            );
        end
    endgenerate

    fx_colpass u_col (
        .tm (t_buf[rd_b]),
        .r  (rd_r),
        .y  (y_q)
    );

    assign last_all  = (rd_r == 2'd3) && (rd_b == nblk_m1);
    assign in_ready  = !full || (out_ready && last_all);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = full && out_ready;

    assign beat.data = y_q;
    assign beat.last = (rd_r == 2'd3);
    assign out_valid = full;
    assign out_row   = beat.data;
    assign out_last  = full && beat.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            wr_r    <= '0;
            rd_r    <= '0;
            rd_b    <= '0;
            nblk_m1 <= '0;
            for (int i = 0; i < MAX_BLK; i++) t_buf[i] <= '0;
        end else begin
            if (out_fire) begin
                if (last_all) begin
                    full <= 1'b0;
                end else begin
                    rd_r <= rd_r + 2'd1;
                    if (rd_r == 2'd3) rd_b <= rd_b + 1'b1;
                end
            end
            if (in_fire) begin
                for (int i = 0; i < MAX_BLK; i++) t_buf[i][wr_r] <= t_new[i];
                wr_r <= wr_r + 2'd1;
                if (wr_r == 2'd0)
                    nblk_m1 <= mode_wide ? BLK_W'(MAX_BLK - 1) : '0;
                if (wr_r == 2'd3) begin
                    full <= 1'b1;
                    rd_r <= '0;
                    rd_b <= '0;
                end
            end
        end
    end

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_last)); // R8
    AST_OVERLAP_FINAL: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && out_valid |-> out_ready && out_last); // R9
    AST_FILL_TO_OUT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && wr_r == 2'd3 |=> out_valid && !out_last); // R7
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready); // R10
    AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(t_buf[0])); // R8
endmodule

// File: tb/fdct4_xform_tb_top.sv
module fdct4_xform_tb_top;
    localparam int PERIOD = 10;

    typedef struct {
        logic [63:0] data;
        bit          last;
        bit          fin;
        string       tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_wide = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_row = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [63:0]  out_row;
    logic         out_last;

    int     n_chk = 0;
    int     n_fail = 0;
    int     overlap = 0;
    bit     ready_all = 1'b0;
    bit     done = 1'b0;
    exp_t   sb[$];

    always #(PERIOD/2) clk = ~clk;

    fdct4_xform dut_i (
        .clk(clk), .rst(rst), .mode_wide(mode_wide),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_row(out_row), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int mval(input int j, input int k);
        int tab [16] = '{23170, 30274, 23170, 12540,
                         23170, 12540, -23170, -30274,
                         23170, -12540, -23170, 30274,
                         23170, -30274, 23170, -12540};
        return tab[j*4 + k];
    endfunction

    // Integer model of one tile; pushes four expected beats
    task automatic model_tile(input logic [127:0] rows [4], input int blk,
                              input bit fin_tile, input string tag);
        int x [4][4];
        int t [4][4];
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                x[i][j] = int'($signed(rows[i][(blk*4+j)*16 +: 16]));
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 4; k++) begin
                longint s = 0;
                longint r;
                shortint h;
                for (int j = 0; j < 4; j++) s += longint'(x[i][j]) * mval(j, k);
                r = (longint'(int'(s)) + 8192) >>> 14;
                h = shortint'(r);
                t[i][k] = h;
            end
        for (int r = 0; r < 4; r++) begin
            exp_t e;
            for (int k = 0; k < 4; k++) begin
                longint s = 0;
                longint q;
                for (int i = 0; i < 4; i++) s += longint'(mval(i, r)) * t[i][k];
                q = (longint'(int'(s)) + 32768) >>> 16;
                e.data[k*16 +: 16] = q[15:0];
            end
            e.last = (r == 3);
            e.fin  = fin_tile && (r == 3);
            e.tag  = tag;
            sb.push_back(e);
        end
    endtask

    task automatic drive_row(input logic [127:0] row, input bit wide);
        @(negedge clk);
        in_valid  = 1'b1;
        in_row    = row;
        mode_wide = wide;
        forever begin
            #(PERIOD/4);
            if (in_ready) begin
                @(posedge clk);
                #1 in_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    // pattern: 0 random, 1 all max, 2 all min, 3 zero, 4 impulse, 5 max left / min right
    task automatic run_tile(input bit wide, input int pattern);
        logic [127:0] rows [4];
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 8; j++) begin
                logic [15:0] v;
                case (pattern)
                    1:       v = 16'h7FFF;
                    2:       v = 16'h8000;
                    3:       v = 16'h0000;
                    4:       v = (i == 1 && j == 2) ? 16'h7FFF : 16'h0000;
                    5:       v = (j < 4) ? 16'h7FFF : 16'h8000;
                    default: v = 16'($urandom);
                endcase
                rows[i][j*16 +: 16] = v;
            end
        if (wide) begin
            model_tile(rows, 0, 1'b0, "R6 left tile");
            model_tile(rows, 1, 1'b1, "R6 right tile");
        end else begin
            model_tile(rows, 0, 1'b1, "R3 R5 narrow tile");
        end
        for (int i = 0; i < 4; i++) drive_row(rows[i], wide);
    endtask

    // Monitor / scoreboard
    logic [63:0] held_row;
    bit          held = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit   rdy;
            bit   front_fin;
            rdy = ready_all ? 1'b1 : ($urandom % 4 != 0);
            if (held && out_valid)
                check(out_row == held_row, "R8 output hold", out_row, held_row);
            held      = out_valid && !rdy;
            held_row  = out_row;
            out_ready = rdy;
            front_fin = (sb.size() > 0) ? sb[0].fin : 1'b0;
            if (out_valid && rdy) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected beat", out_row, 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_row == e.data, {e.tag, " R1 R2 R4 data"}, out_row, e.data);
                    check(out_last == e.last, "R7 out_last", 64'(out_last), 64'(e.last));
                end
            end
            #(PERIOD/4);
            begin
                bit exp_rdy;
                exp_rdy = !out_valid || (rdy && front_fin);
                check(in_ready == exp_rdy, "R8 R9 in_ready", 64'(in_ready), 64'(exp_rdy));
                if (in_valid && in_ready && out_valid && rdy) overlap++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'(sb.size()), 64'h0);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 reset out_valid", 64'(out_valid), 64'h0);
        check(in_ready == 1'b1, "R10 reset in_ready", 64'(in_ready), 64'h1);

        run_tile(1'b0, 3);
        run_tile(1'b0, 4);
        run_tile(1'b0, 1);
        run_tile(1'b0, 2);
        for (int n = 0; n < 6; n++) run_tile(1'b0, 0);
        for (int n = 0; n < 4; n++) run_tile(1'b1, 0);
        run_tile(1'b1, 5);
        run_tile(1'b1, 1);
        run_tile(1'b1, 2);

        // back-to-back with a sink that never stalls: provokes R9 overlap
        ready_all = 1'b1;
        for (int n = 0; n < 4; n++) run_tile(1'b0, 0);
        for (int n = 0; n < 3; n++) run_tile(1'b1, 0);
        run_tile(1'b0, 2);

        while (sb.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
        check(overlap > 0, "R9 final beat and next row in same cycle",
              64'(overlap), 64'h1);
        report();
    end
endmodule